// File: doc/BRIEF.md
# Reduction Operation Count Calculator

This block works out how many element-wise binary operations a parallel tree reduction performs for a given number of elements. That number is then used as the vector length for the remapped loop that carries out the reduction. A two-level loop over doubling strides would give the same count, but here it is replaced by a closed-form sum of seven biased, shifted copies of the element count. The terms are compressed by a carry-save tree and resolved by a single final adder.

The element count comes from one of two places. When the register selector is zero, the current vector length is used. Otherwise the supplied register value is used. A second lane applies the same computation to the current maximum length. With the default configuration the results are registered, so each result appears one cycle after the request and is marked by an output valid.

Top module: `redop_count`

## Requirements
- R1: When `reg_sel` is all zeros the element count is `cur_vlen`; for any non-zero `reg_sel` it is `reg_value`, and `cur_vlen` then has no effect on `op_count`.
- R2: `op_count` equals the sum over k = 0..6 of (n + 2^k - 1) >> (k+1), where n is the selected 7-bit count. This equals the nested-loop rule: the stride starts at 1 and doubles while it is below n, and each round counts one operation per position j = 0, 2·stride, 4·stride, ... for which j + stride < n.
- R3: Counts 0 and 1 give 0, a count of 2 gives 1, and a count of 8 gives 7.
- R4: For any non-zero count n, the result is n - 1.
- R5: `op_count_max` is the same function applied to `cur_maxlen`, whatever the selector is.
- R6: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the results are valid in that same cycle.
- R7: In a cycle that follows a cycle without `in_valid`, both results keep their previous values.
- R8: While `rst_n` is low at a clock edge, `out_valid`, `op_count` and `op_count_max` become 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| reg_sel | input | 5 | Register selector; zero picks the vector length |
| reg_value | input | 7 | Count supplied from a register |
| cur_vlen | input | 7 | Current vector length |
| cur_maxlen | input | 7 | Current maximum length |
| out_valid | output | 1 | Results valid |
| op_count | output | 7 | Operation count for the selected element count |
| op_count_max | output | 7 | Operation count for the maximum length |

## Verification
Every result is due in the cycle after the clock edge that captures its request. The driver changes inputs on the falling edge and pushes the expected pair into a queue at that moment. The monitor samples one nanosecond after each rising edge and pops one entry for every cycle in which `out_valid` is high. A valid with nothing queued, or a non-empty queue at the end, counts as a latency fault. In idle cycles the monitor compares the outputs against the last popped values, which shows that they were held.

// File: rtl/redop_pkg.sv
// Shared sizing for the reduction operation counter.
// Assumes the count width is at least 2 bits.
package redop_pkg;

    localparam int CNT_W_DEF = 7;
    localparam int SEL_W_DEF = 5;

    // Operand count remaining after one layer of 3:2 compression.
    function automatic int csa_next(input int m);
        return (m / 3) * 2 + (m % 3);
    endfunction

    // Operand count at a given layer of the tree.
    function automatic int csa_count_at(input int n, input int layer);
        int m;
        m = n;
        for (int l = 0; l < layer; l++) m = csa_next(m);
        return m;
    endfunction

    // Number of layers needed to bring n operands down to two.
    function automatic int csa_layers(input int n);
        int m;
        int lv;
        m  = n;
        lv = 0;
        while (m > 2) begin
            m  = csa_next(m);
            lv = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/redop_terms.sv
// Builds the biased, shifted terms (n + 2^k - 1) >> (k+1) for k = 0..CNT_W-1.
// Assumes n is unsigned; there is one term per count bit, and terms whose
// bias reaches the count come out as zero.
module redop_terms #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0]            cnt,
    output logic [CNT_W-1:0][CNT_W-1:0] terms
);
    localparam int EXT_W = CNT_W + 1;

    for (genvar k = 0; k < CNT_W; k++) begin : g_term
        localparam logic [EXT_W-1:0] BIAS = EXT_W'((1 << k) - 1);
        logic [EXT_W-1:0] biased;
        // Add the bias for this term, then drop k+1 low bits.
        always_comb begin
            biased   = {1'b0, cnt} + BIAS;
            terms[k] = CNT_W'(biased >> (k + 1));
        end
    end
endmodule

// File: rtl/redop_csa.sv
// One 3:2 carry-save compressor of width W; sums are taken modulo 2^W.
// Assumes W >= 2.
module redop_csa #(
    parameter int W = 7
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    logic [W-1:0] maj;
    // Bitwise sum and majority, with the majority moved up one place.
    always_comb begin
        sum   = a ^ b ^ c;
        maj   = (a & b) | (a & c) | (b & c);
        carry = {maj[W-2:0], 1'b0};
    end
endmodule

// File: rtl/redop_tree.sv
// Adds N operands of width W: layers of 3:2 compressors bring them down to two,
// and one carry-propagate adder finishes. The result is modulo 2^W.
// Assumes N >= 2.
module redop_tree #(
    parameter int N = 7,
    parameter int W = 7
) (
    input  logic [N-1:0][W-1:0] ops,
    output logic [W-1:0]        total
);
    import redop_pkg::*;

    localparam int LAYERS = csa_layers(N);

    logic [W-1:0] lvl [0:LAYERS][0:N-1];

    for (genvar e = 0; e < N; e++) begin : g_in
        assign lvl[0][e] = ops[e];
    end

    for (genvar gl = 0; gl < LAYERS; gl++) begin : g_layer
        localparam int M    = csa_count_at(N, gl);
        localparam int GRP  = M / 3;
        localparam int REM  = M % 3;
        localparam int NEXT = csa_next(M);

        for (genvar g = 0; g < GRP; g++) begin : g_grp
            redop_csa #(.W(W)) i_csa (
                .a    (lvl[gl][3*g]),
                .b    (lvl[gl][3*g+1]),
                .c    (lvl[gl][3*g+2]),
                .sum  (lvl[gl+1][2*g]),
                .carry(lvl[gl+1][2*g+1])
            );
        end
        for (genvar r = 0; r < REM; r++) begin : g_pass
            assign lvl[gl+1][2*GRP+r] = lvl[gl][3*GRP+r];
        end
        for (genvar z = NEXT; z < N; z++) begin : g_zero
            assign lvl[gl+1][z] = '0;
        end
    end

    // Final carry-propagate addition of the two remaining operands.
    always_comb total = lvl[LAYERS][0] + lvl[LAYERS][1];
endmodule

// File: rtl/redop_lane.sv
// One counting lane: term generation followed by the compressor tree.
// Purely combinational; any register stage lives in the caller.
module redop_lane #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ops
);
    logic [CNT_W-1:0][CNT_W-1:0] terms;

    redop_terms #(.CNT_W(CNT_W)) i_terms (
        .cnt  (cnt),
        .terms(terms)
    );

    redop_tree #(.N(CNT_W), .W(CNT_W)) i_tree (
        .ops  (terms),
        .total(ops)
    );
endmodule

// File: rtl/redop_count.sv
// Reduction operation count calculator. Picks the element count (vector
// length when reg_sel is zero, otherwise reg_value), then computes the tree
// reduction operation count for it and for the maximum length.
// OUT_REG=1 gives a one-cycle registered result; OUT_REG=0 is combinational.
// Reset is synchronous and active low.
module redop_count #(
    parameter int CNT_W   = redop_pkg::CNT_W_DEF,
    parameter int SEL_W   = redop_pkg::SEL_W_DEF,
    parameter int OUT_REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [CNT_W-1:0] reg_value,
    input  logic [CNT_W-1:0] cur_vlen,
    input  logic [CNT_W-1:0] cur_maxlen,
    output logic             out_valid,
    output logic [CNT_W-1:0] op_count,
    output logic [CNT_W-1:0] op_count_max
);
    logic [CNT_W-1:0] cnt_sel;
    logic [CNT_W-1:0] ops_sel;
    logic [CNT_W-1:0] ops_max;

    // Choose the element count source.
    always_comb cnt_sel = (reg_sel == '0) ? cur_vlen : reg_value;

    redop_lane #(.CNT_W(CNT_W)) i_lane_sel (
        .cnt(cnt_sel),
        .ops(ops_sel)
    );

    redop_lane #(.CNT_W(CNT_W)) i_lane_max (
        .cnt(cur_maxlen),
        .ops(ops_max)
    );

    if (OUT_REG != 0) begin : g_reg
        // Capture results on a request and hold them otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid    <= 1'b0;
                op_count     <= '0;
                op_count_max <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    op_count     <= ops_sel;
                    op_count_max <= ops_max;
                end
            end
        end
    end else begin : g_comb
        // Pass results straight through.
        always_comb begin
            out_valid    = in_valid;
            op_count     = ops_sel;
            op_count_max = ops_max;
        end
    end
endmodule

// File: rtl/redop_count_chk.sv
// Protocol and value checks for redop_count, attached with bind.
// Only the registered configuration is checked over time.
module redop_count_chk #(
    parameter int CNT_W   = 7,
    parameter int SEL_W   = 5,
    parameter int OUT_REG = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SEL_W-1:0] reg_sel,
    input logic [CNT_W-1:0] reg_value,
    input logic [CNT_W-1:0] cur_vlen,
    input logic [CNT_W-1:0] cur_maxlen,
    input logic             out_valid,
    input logic [CNT_W-1:0] op_count,
    input logic [CNT_W-1:0] op_count_max
);
    logic [CNT_W-1:0] n_chk;
    // Element count the request should have used.
    always_comb n_chk = (reg_sel == '0) ? cur_vlen : reg_value;

    if (OUT_REG != 0) begin : g_chk
        p_reset_r8: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && op_count == '0 && op_count_max == '0));

        p_valid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(op_count) && $stable(op_count_max)));

        p_small_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && n_chk <= CNT_W'(1)) |=> (op_count == '0));

        p_minus_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && n_chk != '0) |=> (op_count == CNT_W'($past(n_chk) - 1'b1)));

        p_max_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && cur_maxlen != '0) |=>
                (op_count_max == CNT_W'($past(cur_maxlen) - 1'b1)));
    end
endmodule

bind redop_count redop_count_chk #(
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W),
    .OUT_REG(OUT_REG)
) i_redop_count_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .reg_sel     (reg_sel),
    .reg_value   (reg_value),
    .cur_vlen    (cur_vlen),
    .cur_maxlen  (cur_maxlen),
    .out_valid   (out_valid),
    .op_count    (op_count),
    .op_count_max(op_count_max)
);

// File: tb/test_redop_count.sv
`timescale 1ns/100ps
// Scoreboard bench for redop_count: a driver queues expected results and a
// monitor compares them one cycle later.
module test_redop_count;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] reg_sel = '0;
    logic [6:0] reg_value = '0;
    logic [6:0] cur_vlen = '0;
    logic [6:0] cur_maxlen = '0;
    logic       out_valid;
    logic [6:0] op_count;
    logic [6:0] op_count_max;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int    q_cnt [$];
    int    q_max [$];
    int    q_n   [$];
    string q_tag [$];

    int  last_cnt = 0;
    int  last_max = 0;
    bit  seen     = 1'b0;

    always #2.5 clk = ~clk;

    redop_count i_redop_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .reg_sel     (reg_sel),
        .reg_value   (reg_value),
        .cur_vlen    (cur_vlen),
        .cur_maxlen  (cur_maxlen),
        .out_valid   (out_valid),
        .op_count    (op_count),
        .op_count_max(op_count_max)
    );

    // Nested-loop reference for the tree reduction operation count.
    function automatic int loop_ops(input int n);
        int step;
        int nstep;
        int j;
        int cnt;
        step = 1;
        cnt  = 0;
        while (step < n) begin
            nstep = step * 2;
            j = 0;
            while (j + step < n) begin
                j   = j + nstep;
                cnt = cnt + 1;
            end
            step = nstep;
        end
        return cnt;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Drive one request on the falling edge and queue its expected results.
    task automatic send(input logic [4:0] sel, input int rv, input int vl, input int mx,
                        input int exp_cnt, input string tag);
        int n;
        @(negedge clk);
        reg_sel    = sel;
        reg_value  = 7'(rv);
        cur_vlen   = 7'(vl);
        cur_maxlen = 7'(mx);
        in_valid   = 1'b1;
        n = (sel == '0) ? vl : rv;
        q_cnt.push_back(exp_cnt);
        q_max.push_back(loop_ops(mx));
        q_n.push_back(n);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            cur_vlen  = 7'(c * 37 + 5);
            reg_value = 7'(c * 11 + 3);
            cur_maxlen = 7'(c * 19 + 9);
        end
    endtask

    // Monitor: sample just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q_cnt.size() == 0) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL R6: actual out_valid 1 expected 0 (nothing pending)");
                end else begin
                    int ec;
                    int em;
                    int en;
                    string tg;
                    ec = q_cnt.pop_front();
                    em = q_max.pop_front();
                    en = q_n.pop_front();
                    tg = q_tag.pop_front();
                    check(tg, int'(op_count), ec);
                    check("R5 max lane", int'(op_count_max), em);
                    if (en != 0) check("R4 n-1", int'(op_count), en - 1);
                    last_cnt = int'(op_count);
                    last_max = int'(op_count_max);
                    seen = 1'b1;
                end
            end else if (seen) begin
                check("R7 hold count", int'(op_count), last_cnt);
                check("R7 hold max", int'(op_count_max), last_max);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset valid", int'(out_valid), 0);
        check("R8 reset count", int'(op_count), 0);
        check("R8 reset max", int'(op_count_max), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: fixed corner values
        send(5'd0, 99, 0, 0, 0, "R3 n=0");
        send(5'd0, 99, 1, 1, 0, "R3 n=1");
        send(5'd0, 99, 2, 2, 1, "R3 n=2");
        send(5'd0, 99, 8, 8, 7, "R3 n=8");
        idle(3);

        // R2: full sweep of the vector-length path, back to back
        for (int n = 0; n < 128; n++)
            send(5'd0, (n * 53) % 128, n, 127 - n, loop_ops(n), "R2 sweep vlen");
        idle(2);

        // R1: register path with a different vector length, gaps in between
        for (int n = 0; n < 128; n++) begin
            send(5'(1 + (n % 31)), n, (n + 64) % 128, (n * 7) % 128, loop_ops(n),
                 "R1 register source");
            if (n % 5 == 0) idle(1 + n % 3);
        end
        idle(2);

        // R1: selector zero ignores reg_value
        send(5'd0, 127, 3, 64, loop_ops(3), "R1 selector zero");
        send(5'd31, 127, 3, 65, loop_ops(127), "R1 selector max");
        idle(4);

        @(negedge clk);
        done = 1'b1;
        check("R6 queue drained", q_cnt.size(), 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R6: watchdog expired, actual running expected finished");
        finish_run();
    end
endmodule